// File: doc/BRIEF.md
# Dual-mode watchdog timer with postscaler

This block is a supervisory counter that can play one of two roles. In watchdog role it counts ticks of a free-running oscillator, given to it as a one-cycle enable `osc_tick`. It therefore keeps counting while the core is asleep. If software fails to clear it in time, it asks for a device reset. A two-bit configuration field picks one of three postscale ratios, which stretch the nominal period by 1, 64 or 256. The field's fourth value switches the watchdog off.

With the watchdog off, the same counter becomes a plain overflow timer. It advances once per core clock and stops while the core sleeps. On overflow it only drops a time-out status flag. Software pulses `clr_wdt` to restart the count, and in timer role this also raises the flag again.

The counter and the postscaler cannot be read or written. They restart on reset, on a clear command, on sleep entry and on an interrupt wake-up from sleep. The only state visible outside is the time-out flag. A watchdog expiry during sleep does not request a reset. It wakes the core with a one-cycle pulse instead.

Top module: `wdog_dual`

## Requirements
- R1: While `rst` is high the counter and the postscaler clear, and `dev_rst_req` and `wake_pulse` read 0 in the cycle after. Counting resumes on the first clock edge at which `rst` is low.
- R2: `to_flag` holds 1 from power-up and `rst` never changes it, so a 0 left by a time-out survives the reset that the time-out requested.
- R3: `ps_cfg` = 2'b11, 2'b10 and 2'b01 select watchdog role with a divide of 1, POST_MID (64) and POST_MAX (256). A time-out falls on the edge of the BASE_TICKS×divide-th `osc_tick` after the last clear.
- R4: A watchdog time-out while awake raises `dev_rst_req` for exactly one cycle, starting in the cycle after the edge. In that same cycle `to_flag` reads 0.
- R5: `clr_wdt`, `sleep_enter`, and `irq_wake` while asleep each restart the count from zero. `irq_wake` while awake has no effect on the time-out moment.
- R6: A clear that falls on the very edge that would time out wins. No reset request or wake pulse follows, `to_flag` stays 1, and a full period starts over.
- R7: In watchdog role the count advances only on `osc_tick` and continues during sleep. A time-out while asleep gives a one-cycle `wake_pulse` with no `dev_rst_req`, sets `to_flag` to 0 and ends the sleep.
- R8: With `ps_cfg` = 2'b00 the count advances on every clock while awake. Overflow after TMR_CYCLES cycles (default 65536) sets `to_flag` to 0. This role never drives `dev_rst_req` or `wake_pulse`.
- R9: In timer role the count is frozen while asleep, so no overflow occurs however long the sleep lasts.
- R10: `clr_wdt` or `sleep_enter` sets `to_flag` to 1 in the cycle after, in either role.
- R11: `dev_rst_req` and `wake_pulse` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running clock; one cycle equals one core clock when awake |
| rst | input | 1 | Synchronous active-high reset-active indication |
| ps_cfg | input | 2 | Role and postscale select: 00 off/timer, 01 ÷256, 10 ÷64, 11 ÷1 |
| osc_tick | input | 1 | One-cycle enable standing for an edge of the independent oscillator |
| clr_wdt | input | 1 | Clear-watchdog command pulse |
| sleep_enter | input | 1 | Sleep-entry pulse |
| irq_wake | input | 1 | Interrupt wake-up pulse |
| dev_rst_req | output | 1 | Registered one-cycle device reset request |
| wake_pulse | output | 1 | Registered one-cycle wake from sleep on watchdog expiry |
| to_flag | output | 1 | Time-out status, 0 after a time-out |

## Verification
The collision that matters is a restart (clear command) landing on the same edge as the final tick of a period. The bench provokes it by watching its own model's tick count. It raises `clr_wdt` just before the edge on which the model expects expiry. The result is judged by the absence of `dev_rst_req` in the next cycle, `to_flag` still at 1, and the next expiry arriving a full BASE_TICKS ticks later. A second overlap, sleep and expiry, is judged by `wake_pulse` replacing `dev_rst_req` in the same cycle.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;

  // Role / postscale select encodings
  typedef enum logic [1:0] {
    PS_OFF     = 2'b00,
    PS_DIV_MAX = 2'b01,
    PS_DIV_MID = 2'b10,
    PS_DIV_ONE = 2'b11
  } ps_sel_e;

  // Divide ratio for a select code; 0 means no watchdog tap
  function automatic int unsigned div_of(int unsigned sel, int unsigned mid,
                                         int unsigned max);
    case (sel)
      3:       return 1;
      2:       return mid;
      1:       return max;
      default: return 0;
    endcase
  endfunction

  function automatic int unsigned width_of(int unsigned span);
    return (span <= 2) ? 1 : $clog2(span);
  endfunction

endpackage

// File: rtl/wdog_base_cnt.sv
`timescale 1ns/1ps
module wdog_base_cnt #(
  parameter int unsigned BASE_TICKS = 32,
  parameter int unsigned TMR_CYCLES = 65536
) (
  input  logic clk,
  input  logic clear,
  input  logic step,
  input  logic wd_mode,
  output logic wrap
);
  localparam int unsigned SPAN = (BASE_TICKS > TMR_CYCLES) ? BASE_TICKS : TMR_CYCLES;
  localparam int unsigned CW   = wdog_pkg::width_of(SPAN);
  localparam logic [CW-1:0] WD_LIMIT  = CW'(BASE_TICKS - 1);
  localparam logic [CW-1:0] TMR_LIMIT = CW'(TMR_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit;
  logic          at_limit;

  assign limit    = wd_mode ? WD_LIMIT : TMR_LIMIT;
  assign at_limit = (cnt_q == limit);
  assign wrap     = step & at_limit;

  always_ff @(posedge clk) begin
    if (clear)
      cnt_q <= '0;
    else if (step)
      cnt_q <= at_limit ? '0 : cnt_q + 1'b1;
  end

endmodule

// File: rtl/wdog_postscaler.sv
`timescale 1ns/1ps
module wdog_postscaler #(
  parameter int unsigned POST_MID = 64,
  parameter int unsigned POST_MAX = 256
) (
  input  logic       clk,
  input  logic       clear,
  input  logic       adv,
  input  logic [1:0] sel,
  output logic       tap_hit
);
  localparam int unsigned PW = wdog_pkg::width_of(POST_MAX);

  logic [PW-1:0] post_q;
  logic [3:0]    tap;

  always_ff @(posedge clk) begin
    if (clear)
      post_q <= '0;
    else if (adv)
      post_q <= post_q + 1'b1;
  end

  // One tap per select code; power-of-two ratios compare the low bits
  for (genvar g = 0; g < 4; g++) begin : g_tap
    localparam int unsigned DIV = wdog_pkg::div_of(g, POST_MID, POST_MAX);
    if (DIV == 0) begin : g_off
      assign tap[g] = 1'b0;
    end else begin : g_on
      localparam logic [PW-1:0] MASK = PW'(DIV - 1);
      assign tap[g] = ((post_q & MASK) == MASK);
    end
  end

  assign tap_hit = tap[sel];

endmodule

// File: rtl/wdog_ctrl.sv
`timescale 1ns/1ps
module wdog_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic wd_mode,
  input  logic wrap,
  input  logic tap_hit,
  input  logic clr_wdt,
  input  logic sleep_enter,
  input  logic irq_wake,
  output logic clear_all,
  output logic asleep,
  output logic dev_rst_req,
  output logic wake_pulse,
  output logic to_flag
);
  logic asleep_q, req_q, wake_q;
  logic to_q = 1'b1;
  logic hit, wd_hit;

  assign clear_all = rst | clr_wdt | sleep_enter | (irq_wake & asleep_q);
  assign hit       = ~clear_all & wrap & (~wd_mode | tap_hit);
  assign wd_hit    = hit & wd_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      asleep_q <= 1'b0;
      req_q    <= 1'b0;
      wake_q   <= 1'b0;
    end else begin
      req_q  <= wd_hit & ~asleep_q;
      wake_q <= wd_hit & asleep_q;
      if (sleep_enter)
        asleep_q <= 1'b1;
      else if (irq_wake | wd_hit)
        asleep_q <= 1'b0;
    end
  end

  // Status flag is not touched by reset so a time-out stays visible
  always_ff @(posedge clk) begin
    if (hit)
      to_q <= 1'b0;
    else if (clr_wdt | sleep_enter)
      to_q <= 1'b1;
  end

  assign asleep      = asleep_q;
  assign dev_rst_req = req_q;
  assign wake_pulse  = wake_q;
  assign to_flag     = to_q;

endmodule

// File: rtl/wdog_dual.sv
`timescale 1ns/1ps
module wdog_dual #(
  parameter int unsigned BASE_TICKS = 32,
  parameter int unsigned TMR_CYCLES = 65536,
  parameter int unsigned POST_MID   = 64,
  parameter int unsigned POST_MAX   = 256
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] ps_cfg,
  input  logic       osc_tick,
  input  logic       clr_wdt,
  input  logic       sleep_enter,
  input  logic       irq_wake,
  output logic       dev_rst_req,
  output logic       wake_pulse,
  output logic       to_flag
);
  logic wd_mode, asleep, clear_all, step, wrap, tap_hit;

  assign wd_mode = (ps_cfg != wdog_pkg::PS_OFF);
  assign step    = wd_mode ? osc_tick : ~asleep;

  wdog_base_cnt #(
    .BASE_TICKS(BASE_TICKS),
    .TMR_CYCLES(TMR_CYCLES)
  ) u_base (
    .clk    (clk),
    .clear  (clear_all),
    .step   (step),
    .wd_mode(wd_mode),
    .wrap   (wrap)
  );

  wdog_postscaler #(
    .POST_MID(POST_MID),
    .POST_MAX(POST_MAX)
  ) u_post (
    .clk    (clk),
    .clear  (clear_all),
    .adv    (wd_mode & wrap),
    .sel    (ps_cfg),
    .tap_hit(tap_hit)
  );

  wdog_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .wd_mode    (wd_mode),
    .wrap       (wrap),
    .tap_hit    (tap_hit),
    .clr_wdt    (clr_wdt),
    .sleep_enter(sleep_enter),
    .irq_wake   (irq_wake),
    .clear_all  (clear_all),
    .asleep     (asleep),
    .dev_rst_req(dev_rst_req),
    .wake_pulse (wake_pulse),
    .to_flag    (to_flag)
  );

endmodule

// File: rtl/wdog_dual_chk.sv
`timescale 1ns/1ps
module wdog_dual_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] ps_cfg,
  input logic       clr_wdt,
  input logic       sleep_enter,
  input logic       dev_rst_req,
  input logic       wake_pulse,
  input logic       to_flag
);
  // R1
  rst_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!dev_rst_req && !wake_pulse));

  // R2
  to_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(to_flag) |-> $past(clr_wdt || sleep_enter));

  // R4
  req_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    dev_rst_req |=> !dev_rst_req);

  // R4
  req_clears_to_chk: assert property (@(posedge clk) disable iff (rst)
    dev_rst_req |-> !to_flag);

  // R7
  wake_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    wake_pulse |=> !wake_pulse);

  // R8
  timer_no_reset_chk: assert property (@(posedge clk) disable iff (rst)
    (ps_cfg == 2'b00 && $past(ps_cfg) == 2'b00) |-> (!dev_rst_req && !wake_pulse));

  // R10
  clr_sets_to_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_wdt || sleep_enter) |=> to_flag);

  // R11
  excl_out_chk: assert property (@(posedge clk) disable iff (rst)
    !(dev_rst_req && wake_pulse));

endmodule

bind wdog_dual wdog_dual_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .ps_cfg     (ps_cfg),
  .clr_wdt    (clr_wdt),
  .sleep_enter(sleep_enter),
  .dev_rst_req(dev_rst_req),
  .wake_pulse (wake_pulse),
  .to_flag    (to_flag)
);

// File: tb/wdog_dual_test.sv
`timescale 1ns/1ps
module wdog_dual_test;
  localparam int BASE = 32;
  localparam int TMR  = 4096;
  localparam int MID  = 64;
  localparam int MAX  = 256;

  logic clk = 1'b0, rst = 1'b1;
  logic [1:0] cfg = 2'b11;
  logic osc_tick = 1'b0, clr_wdt = 1'b0, sleep_enter = 1'b0, irq_wake = 1'b0;
  logic dev_rst_req, wake_pulse, to_flag;

  int n_chk = 0, n_err = 0;
  int ticks_used = 0, cyc = 0;
  bit seen_rst = 0, seen_wake = 0, done = 0;

  wdog_dual #(.BASE_TICKS(BASE), .TMR_CYCLES(TMR), .POST_MID(MID), .POST_MAX(MAX)) uut (
    .clk(clk), .rst(rst), .ps_cfg(cfg), .osc_tick(osc_tick), .clr_wdt(clr_wdt),
    .sleep_enter(sleep_enter), .irq_wake(irq_wake), .dev_rst_req(dev_rst_req),
    .wake_pulse(wake_pulse), .to_flag(to_flag));

  always #10 clk = ~clk;
  always @(negedge clk) osc_tick <= !osc_tick;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int period(logic [1:0] c);
    case (c)
      2'b11:   return BASE;
      2'b10:   return BASE * MID;
      2'b01:   return BASE * MAX;
      default: return TMR;
    endcase
  endfunction

  // Behavioural reference: event count since the last restart
  int ev = 0;
  bit m_sleep = 0, m_to = 1, m_req = 0, m_wake = 0;
  always @(posedge clk) begin
    bit wd, clr, stp, tmo;
    wd  = (cfg != 2'b00);
    clr = rst || clr_wdt || sleep_enter || (irq_wake && m_sleep);
    stp = wd ? osc_tick : !m_sleep;
    tmo = 0;
    if (clr) ev = 0;
    else if (stp) begin
      ev++;
      if (ev >= period(cfg)) begin tmo = 1; ev = 0; end
    end
    m_req  = tmo && wd && !m_sleep;
    m_wake = tmo && wd && m_sleep;
    if (tmo) m_to = 0;
    else if (clr_wdt || sleep_enter) m_to = 1;
    if (rst) m_sleep = 0;
    else if (sleep_enter) m_sleep = 1;
    else if (irq_wake || m_wake) m_sleep = 0;
  end

  always @(negedge clk) begin
    cyc++;
    if (osc_tick) ticks_used++;
    if (dev_rst_req) seen_rst = 1;
    if (wake_pulse) seen_wake = 1;
    if (!done) begin
      chk(dev_rst_req == m_req, "R4 model dev_rst_req", dev_rst_req, m_req);
      chk(wake_pulse == m_wake, "R7 model wake_pulse", wake_pulse, m_wake);
      chk(to_flag == m_to, "R10 model to_flag", to_flag, m_to);
      chk(!(dev_rst_req && wake_pulse), "R11 exclusive outputs", dev_rst_req, 0);
    end
  end

  task automatic pulse(input int which);
    @(negedge clk); #1;
    case (which)
      0: rst = 1;
      1: clr_wdt = 1;
      2: sleep_enter = 1;
      3: irq_wake = 1;
      default: ;
    endcase
    @(negedge clk); #1;
    rst = 0; clr_wdt = 0; sleep_enter = 0; irq_wake = 0;
  endtask

  task automatic wait_out(input int lim);
    int g = 0;
    while (!(dev_rst_req || wake_pulse) && g < lim) begin
      @(negedge clk); #1;
      g++;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic finish_run;
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    int t0, c0;
    repeat (3) @(negedge clk);
    #1;
    // R1 / R2 reset state
    chk(!dev_rst_req && !wake_pulse, "R1 outputs in reset", dev_rst_req | wake_pulse, 0);
    chk(to_flag == 1, "R2 power-up flag", to_flag, 1);
    rst = 0;
    t0 = ticks_used;
    wait_out(400);
    chk(ticks_used - t0 == BASE, "R1 R3 first period after reset", ticks_used - t0, BASE);
    chk(dev_rst_req == 1, "R4 reset request", dev_rst_req, 1);
    chk(to_flag == 0, "R4 flag cleared", to_flag, 0);
    idle(1);
    chk(dev_rst_req == 0, "R4 single cycle", dev_rst_req, 0);
    pulse(0);
    chk(to_flag == 0, "R2 flag kept through reset", to_flag, 0);
    pulse(1);
    chk(to_flag == 1, "R10 clear sets flag", to_flag, 1);

    // R5 regular clearing keeps it quiet
    seen_rst = 0;
    for (int i = 0; i < 10; i++) begin
      idle(40);
      pulse(1);
    end
    chk(!seen_rst, "R5 regular clears", seen_rst, 0);

    // R5 interrupt wake while awake is ignored
    pulse(1);
    t0 = ticks_used;
    idle(20);
    pulse(3);
    wait_out(400);
    chk(dev_rst_req && (ticks_used - t0 == BASE), "R5 awake irq_wake ignored", ticks_used - t0, BASE);

    // R6 clear on the expiry edge
    pulse(1);
    begin
      int g = 0;
      while (!(osc_tick && ev == period(cfg) - 1) && g < 1000) begin
        @(negedge clk); #1;
        g++;
      end
    end
    clr_wdt = 1;
    @(negedge clk); #1;
    clr_wdt = 0;
    chk(dev_rst_req == 0, "R6 no request on collision", dev_rst_req, 0);
    chk(to_flag == 1, "R6 flag stays set", to_flag, 1);
    t0 = ticks_used;
    wait_out(400);
    chk(ticks_used - t0 == BASE, "R6 full period after collision", ticks_used - t0, BASE);

    // R7 expiry during sleep wakes instead of resetting
    pulse(1);
    pulse(2);
    t0 = ticks_used;
    wait_out(400);
    chk(wake_pulse == 1 && dev_rst_req == 0, "R7 wake instead of reset", wake_pulse, 1);
    chk(ticks_used - t0 == BASE, "R7 counts in sleep", ticks_used - t0, BASE);
    chk(to_flag == 0, "R7 flag cleared", to_flag, 0);

    // R5 interrupt wake from sleep restarts
    pulse(2);
    idle(30);
    pulse(3);
    t0 = ticks_used;
    wait_out(400);
    chk(dev_rst_req && (ticks_used - t0 == BASE), "R5 irq wake restarts", ticks_used - t0, BASE);

    // R3 larger postscale ratios
    cfg = 2'b10;
    pulse(0);
    t0 = ticks_used;
    wait_out(10000);
    chk(dev_rst_req && (ticks_used - t0 == BASE * MID), "R3 mid ratio", ticks_used - t0, BASE * MID);
    cfg = 2'b01;
    pulse(0);
    t0 = ticks_used;
    wait_out(40000);
    chk(dev_rst_req && (ticks_used - t0 == BASE * MAX), "R3 max ratio", ticks_used - t0, BASE * MAX);

    // R8 timer role
    cfg = 2'b00;
    pulse(0);
    pulse(1);
    seen_rst = 0; seen_wake = 0;
    c0 = cyc;
    begin
      int g = 0;
      while (to_flag && g < 3 * TMR) begin
        @(negedge clk); #1;
        g++;
      end
    end
    chk(cyc - c0 == TMR, "R8 overflow period", cyc - c0, TMR);
    chk(!seen_rst && !seen_wake, "R8 no reset or wake", seen_rst | seen_wake, 0);
    pulse(1);
    chk(to_flag == 1, "R10 timer clear sets flag", to_flag, 1);

    // R9 frozen in sleep
    pulse(2);
    idle(TMR + 200);
    chk(to_flag == 1 && !seen_wake, "R9 no overflow asleep", to_flag, 1);
    pulse(3);
    c0 = cyc;
    begin
      int g = 0;
      while (to_flag && g < 3 * TMR) begin
        @(negedge clk); #1;
        g++;
      end
    end
    chk(cyc - c0 == TMR, "R9 restarts after wake", cyc - c0, TMR);

    idle(4);
    finish_run();
  end

endmodule